// File: doc/BRIEF.md
# Power Delivery Sink Capability Matcher

This block picks which power offer a USB Type-C sink should request from an attached source. Software or a protocol engine loads the source's power data objects into a small offer bank and states how many are valid. The sink configuration gives an acceptable voltage window (lower and upper bound, in 50 mV steps) and a current need made of a coarse and a fine part (in 10 mA steps). A start pulse launches a scan. The scan examines one offer per clock, beginning with the highest-voltage offer and moving down. The first fixed-supply offer that fits the window and carries enough current is chosen. Its 1-based object position and the request values are then reported with a one-cycle done pulse.

When nothing fits, the block falls back to the mandatory 5 V offer at 900 mA. It also raises a safe-5V output that enables a reduced-power supply path. The block also drives the two sink capability objects that describe this sink. In addition, it watches a live VBUS reading in millivolts and flags any value that lies outside the configured window widened by 20% on each side.

Top module: `pd_sink_matcher`

## Requirements
- R1: After start, offers are examined one per clock from index count-1 down to index 0, and the first qualifying offer is selected. Done is due exactly count-k cycles after the start edge for a match at index k. sel_pos is k+1, req_volt is that offer's voltage field, and req_curr is coarse+fine.
- R2: An offer qualifies only if its voltage field (bits 19:10, 50 mV units) is at least cfg_vmin and at most cfg_vmax. Both bounds are inclusive.
- R3: An offer qualifies only if its current field (bits 9:0, 10 mA units) is at least cfg_i_coarse + cfg_i_fine. Equality passes.
- R4: An offer whose type field (bits 31:30) is not 00 (fixed supply) never qualifies.
- R5: When no offer qualifies, done is due max(count,1) cycles after the start edge, with sel_pos=1, req_volt=100 (5 V), req_curr=90 (900 mA) and safe_5v=1. A later successful scan clears safe_5v.
- R6: sink_pdo1 has type 00, voltage field 100 and current field 90. Its bit 28 (higher capability) is 1 exactly when cfg_vmin > 100.
- R7: sink_pdo2 has type 10 in bits 31:30, cfg_vmax in bits 29:20, cfg_vmin in bits 19:10, and coarse+fine saturated to 1023 in bits 9:0.
- R8: vbus_fault, one cycle after vbus_mv is sampled, is 1 exactly when vbus_mv < Vmin - Vmin/5 or vbus_mv > Vmax + Vmax/5. Here Vmin = 50*cfg_vmin and Vmax = 50*cfg_vmax in millivolts, with integer division.
- R9: A start pulse that arrives while busy is high does not restart or extend the scan, and it does not change the result.
- R10: Synchronous reset clears busy, done, sel_pos, req_volt, req_curr, safe_5v and vbus_fault.
- R11: done is a single-cycle pulse that only follows a cycle with busy high. Busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ofr_wr_en | input | 1 | Write strobe for the offer bank |
| ofr_wr_idx | input | 3 | Offer bank slot to write (0..6) |
| ofr_wr_data | input | 32 | Source power data object to store |
| ofr_count | input | 3 | Number of valid offers (0..7) |
| cfg_vmin | input | 10 | Minimum voltage, 50 mV units |
| cfg_vmax | input | 10 | Maximum voltage, 50 mV units |
| cfg_i_coarse | input | 10 | Coarse current need, 10 mA units |
| cfg_i_fine | input | 10 | Fine current need, 10 mA units |
| start | input | 1 | Scan launch pulse |
| vbus_mv | input | 16 | Measured VBUS in millivolts |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle scan completion pulse |
| sel_pos | output | 3 | Selected object position, 1-based |
| req_volt | output | 10 | Requested voltage, 50 mV units |
| req_curr | output | 11 | Requested current, 10 mA units |
| safe_5v | output | 1 | Fallback taken; enables reduced-power path |
| sink_pdo1 | output | 32 | Sink capability object 1 (fixed 5 V) |
| sink_pdo2 | output | 32 | Sink capability object 2 (variable) |
| vbus_fault | output | 1 | VBUS outside the widened window |

## Verification
Scan results are due count-k cycles after the start edge for a match at index k, or max(count,1) cycles after it for the fallback. The bench therefore counts clock edges from the start edge until done appears and compares that count with the value its own reference scan predicts, and it checks the result fields in that same cycle. The sink capability objects are combinational and are checked half a cycle after the configuration changes. The VBUS fault flag is registered, so it is sampled on the falling edge that follows the first rising edge after vbus_mv is driven. All inputs change on falling edges and all outputs are read there, away from the active edge.

// File: rtl/pd_match_pkg.sv
package pd_match_pkg;

    localparam int NUM_OFFERS  = 7;
    localparam int IDX_W       = 3;
    localparam int VOLT_W      = 10;
    localparam int CURR_W      = 10;
    localparam int MV_W        = 17;
    localparam int MV_PER_STEP = 50;

    localparam logic [VOLT_W-1:0] SAFE_VOLT = VOLT_W'(100);
    localparam logic [CURR_W-1:0] SAFE_CURR = CURR_W'(90);

    typedef enum logic [1:0] {
        SUP_FIXED = 2'b00,
        SUP_BATT  = 2'b01,
        SUP_VAR   = 2'b10,
        SUP_AUGM  = 2'b11
    } supply_kind_e;

    typedef struct packed {
        supply_kind_e      kind;
        logic [9:0]        upper;
        logic [VOLT_W-1:0] volt;
        logic [CURR_W-1:0] curr;
    } pdo_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic logic offer_fits(input pdo_t o,
                                        input logic [VOLT_W-1:0] vmin,
                                        input logic [VOLT_W-1:0] vmax,
                                        input logic [CURR_W:0]   need);
        return (o.kind == SUP_FIXED) && (o.volt >= vmin) && (o.volt <= vmax)
               && ({1'b0, o.curr} >= need);
    endfunction

    function automatic logic [MV_W-1:0] steps_to_mv(input logic [VOLT_W-1:0] s);
        return MV_W'(s) * MV_W'(MV_PER_STEP);
    endfunction

endpackage

// File: rtl/pdo_bank.sv
module pdo_bank
    import pd_match_pkg::*;
#(
    parameter int DEPTH = NUM_OFFERS,
    parameter int AW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_idx,
    output pdo_t          rd_pdo
);
    pdo_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (wr_en && (32'(wr_idx) == g)) begin
                slot_q[g] <= pdo_t'(wr_data);
            end
        end
    end

    always_comb begin
        rd_pdo = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (32'(rd_idx) == i) rd_pdo = slot_q[i];
        end
    end
endmodule

// File: rtl/pdo_scanner.sv
module pdo_scanner
    import pd_match_pkg::*;
#(
    parameter int AW = IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     count,
    input  logic [VOLT_W-1:0] vmin,
    input  logic [VOLT_W-1:0] vmax,
    input  logic [CURR_W:0]   need,
    input  pdo_t              offer,
    output logic [AW-1:0]     rd_idx,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     sel_pos,
    output logic [VOLT_W-1:0] req_volt,
    output logic [CURR_W:0]   req_curr,
    output logic              safe_5v
);
    scan_state_e     st_q;
    logic [AW:0]     idx_q;
    logic            hit;
    logic            last;

    assign rd_idx = idx_q[AW-1:0];
    assign hit    = !idx_q[AW] && offer_fits(offer, vmin, vmax, need);
    assign last   = idx_q[AW] || (idx_q == '0);
    assign busy   = (st_q == ST_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            idx_q    <= '0;
            done     <= 1'b0;
            sel_pos  <= '0;
            req_volt <= '0;
            req_curr <= '0;
            safe_5v  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_SCAN;
                        idx_q <= {1'b0, count} - (AW+1)'(1);
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        st_q     <= ST_IDLE;
                        done     <= 1'b1;
                        sel_pos  <= idx_q[AW-1:0] + AW'(1);
                        req_volt <= offer.volt;
                        req_curr <= need;
                        safe_5v  <= 1'b0;
                    end else if (last) begin
                        st_q     <= ST_IDLE;
                        done     <= 1'b1;
                        sel_pos  <= AW'(1);
                        req_volt <= SAFE_VOLT;
                        req_curr <= (CURR_W+1)'(SAFE_CURR);
                        safe_5v  <= 1'b1;
                    end else begin
                        idx_q <= idx_q - (AW+1)'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sink_cap_gen.sv
module sink_cap_gen
    import pd_match_pkg::*;
(
    input  logic [VOLT_W-1:0] vmin,
    input  logic [VOLT_W-1:0] vmax,
    input  logic [CURR_W:0]   need,
    output logic [31:0]       pdo_fixed,
    output logic [31:0]       pdo_var
);
    localparam logic [CURR_W-1:0] CURR_MAX = '1;

    logic [CURR_W-1:0] need_sat;

    assign need_sat = need[CURR_W] ? CURR_MAX : need[CURR_W-1:0];

    always_comb begin
        pdo_fixed        = '0;
        pdo_fixed[31:30] = SUP_FIXED;
        pdo_fixed[28]    = (vmin > SAFE_VOLT);
        pdo_fixed[19:10] = SAFE_VOLT;
        pdo_fixed[9:0]   = SAFE_CURR;

        pdo_var          = '0;
        pdo_var[31:30]   = SUP_VAR;
        pdo_var[29:20]   = vmax;
        pdo_var[19:10]   = vmin;
        pdo_var[9:0]     = need_sat;
    end
endmodule

// File: rtl/vbus_window.sv
module vbus_window
    import pd_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VOLT_W-1:0] vmin,
    input  logic [VOLT_W-1:0] vmax,
    input  logic [15:0]       vbus_mv,
    output logic              fault
);
    logic [MV_W-1:0] lo_mv, hi_mv, min_mv, max_mv, meas;

    assign min_mv = steps_to_mv(vmin);
    assign max_mv = steps_to_mv(vmax);
    assign lo_mv  = min_mv - min_mv / MV_W'(5);
    assign hi_mv  = max_mv + max_mv / MV_W'(5);
    assign meas   = MV_W'(vbus_mv);

    always_ff @(posedge clk) begin
        if (rst) fault <= 1'b0;
        else     fault <= (meas < lo_mv) || (meas > hi_mv);
    end
endmodule

// File: rtl/pd_sink_matcher.sv
module pd_sink_matcher
    import pd_match_pkg::*;
#(
    parameter int N_OFR = NUM_OFFERS,
    parameter int AW    = IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ofr_wr_en,
    input  logic [AW-1:0]     ofr_wr_idx,
    input  logic [31:0]       ofr_wr_data,
    input  logic [AW-1:0]     ofr_count,
    input  logic [VOLT_W-1:0] cfg_vmin,
    input  logic [VOLT_W-1:0] cfg_vmax,
    input  logic [CURR_W-1:0] cfg_i_coarse,
    input  logic [CURR_W-1:0] cfg_i_fine,
    input  logic              start,
    input  logic [15:0]       vbus_mv,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     sel_pos,
    output logic [VOLT_W-1:0] req_volt,
    output logic [CURR_W:0]   req_curr,
    output logic              safe_5v,
    output logic [31:0]       sink_pdo1,
    output logic [31:0]       sink_pdo2,
    output logic              vbus_fault
);
    logic [CURR_W:0] need;
    logic [AW-1:0]   rd_idx;
    pdo_t            cur_offer;

    assign need = {1'b0, cfg_i_coarse} + {1'b0, cfg_i_fine};

    pdo_bank #(.DEPTH(N_OFR), .AW(AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ofr_wr_en),
        .wr_idx  (ofr_wr_idx),
        .wr_data (ofr_wr_data),
        .rd_idx  (rd_idx),
        .rd_pdo  (cur_offer)
    );

    pdo_scanner #(.AW(AW)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .count    (ofr_count),
        .vmin     (cfg_vmin),
        .vmax     (cfg_vmax),
        .need     (need),
        .offer    (cur_offer),
        .rd_idx   (rd_idx),
        .busy     (busy),
        .done     (done),
        .sel_pos  (sel_pos),
        .req_volt (req_volt),
        .req_curr (req_curr),
        .safe_5v  (safe_5v)
    );

    sink_cap_gen u_caps (
        .vmin      (cfg_vmin),
        .vmax      (cfg_vmax),
        .need      (need),
        .pdo_fixed (sink_pdo1),
        .pdo_var   (sink_pdo2)
    );

    vbus_window u_vwin (
        .clk     (clk),
        .rst     (rst),
        .vmin    (cfg_vmin),
        .vmax    (cfg_vmax),
        .vbus_mv (vbus_mv),
        .fault   (vbus_fault)
    );
endmodule

// File: rtl/pd_sink_matcher_chk.sv
module pd_sink_matcher_chk
    import pd_match_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [IDX_W-1:0]  sel_pos,
    input logic [VOLT_W-1:0] req_volt,
    input logic [CURR_W:0]   req_curr,
    input logic              safe_5v,
    input logic              vbus_fault,
    input logic [VOLT_W-1:0] cfg_vmin,
    input logic [VOLT_W-1:0] cfg_vmax
);
    assert_window_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !safe_5v) |-> (req_volt >= cfg_vmin && req_volt <= cfg_vmax));

    assert_fallback_R5: assert property (@(posedge clk) disable iff (rst)
        (done && safe_5v) |-> (sel_pos == 3'd1 && req_volt == 10'd100 && req_curr == 11'd90));

    assert_match_pos_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !safe_5v) |-> (sel_pos != '0));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!busy && !done && !safe_5v && !vbus_fault && sel_pos == '0));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

bind pd_sink_matcher pd_sink_matcher_chk u_chk (.*);

// File: tb/pd_sink_matcher_tb.sv
module pd_sink_matcher_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ofr_wr_en = 1'b0;
    logic [2:0]  ofr_wr_idx = '0;
    logic [31:0] ofr_wr_data = '0;
    logic [2:0]  ofr_count = '0;
    logic [9:0]  cfg_vmin = 10'd100, cfg_vmax = 10'd400;
    logic [9:0]  cfg_i_coarse = '0, cfg_i_fine = '0;
    logic        start = 1'b0;
    logic [15:0] vbus_mv = '0;
    logic        busy, done, safe_5v, vbus_fault;
    logic [2:0]  sel_pos;
    logic [9:0]  req_volt;
    logic [10:0] req_curr;
    logic [31:0] sink_pdo1, sink_pdo2;

    int checks = 0;
    int errors = 0;
    logic [31:0] ofr_m [7];

    always #4 clk = ~clk;

    pd_sink_matcher u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pdo(input int kind, input int v, input int i);
        return {kind[1:0], 10'd0, v[9:0], i[9:0]};
    endfunction

    function automatic int ref_pick(input int n);
        int need = int'(cfg_i_coarse) + int'(cfg_i_fine);
        for (int k = n - 1; k >= 0; k--) begin
            if (ofr_m[k][31:30] == 2'b00 && int'(ofr_m[k][19:10]) >= int'(cfg_vmin)
                && int'(ofr_m[k][19:10]) <= int'(cfg_vmax) && int'(ofr_m[k][9:0]) >= need)
                return k;
        end
        return -1;
    endfunction

    function automatic bit ref_fault(input int mv);
        int lo = 50 * int'(cfg_vmin);
        int hi = 50 * int'(cfg_vmax);
        lo = lo - lo / 5;
        hi = hi + hi / 5;
        return (mv < lo) || (mv > hi);
    endfunction

    task automatic wr_offer(input int idx, input logic [31:0] d);
        @(negedge clk);
        ofr_wr_en = 1'b1; ofr_wr_idx = idx[2:0]; ofr_wr_data = d;
        ofr_m[idx] = d;
        @(negedge clk);
        ofr_wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int vmin, input int vmax, input int ic, input int ifn);
        @(negedge clk);
        cfg_vmin = vmin[9:0]; cfg_vmax = vmax[9:0];
        cfg_i_coarse = ic[9:0]; cfg_i_fine = ifn[9:0];
    endtask

    task automatic scan_check(input int n, input bit extra_start, input string req);
        int k = ref_pick(n);
        int lat = 0;
        int exp_lat = (k >= 0) ? (n - k) : ((n == 0) ? 1 : n);
        @(negedge clk);
        ofr_count = n[2:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (extra_start && lat == 1);
        end
        start = 1'b0;
        chk(lat == exp_lat, req, "latency", lat, exp_lat);
        if (k >= 0) begin
            chk(sel_pos == 3'(k + 1), req, "sel_pos", sel_pos, k + 1);
            chk(req_volt == ofr_m[k][19:10], req, "req_volt", req_volt, ofr_m[k][19:10]);
            chk(int'(req_curr) == int'(cfg_i_coarse) + int'(cfg_i_fine), req, "req_curr",
                req_curr, int'(cfg_i_coarse) + int'(cfg_i_fine));
            chk(safe_5v == 1'b0, req, "safe_5v", safe_5v, 0);
        end else begin
            chk(sel_pos == 3'd1, "R5", "fallback sel_pos", sel_pos, 1);
            chk(req_volt == 10'd100, "R5", "fallback volt", req_volt, 100);
            chk(req_curr == 11'd90, "R5", "fallback curr", req_curr, 90);
            chk(safe_5v == 1'b1, "R5", "safe_5v", safe_5v, 1);
        end
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R11", "idle after done", {done, busy}, 0);
    endtask

    task automatic caps_check();
        int need = int'(cfg_i_coarse) + int'(cfg_i_fine);
        logic [31:0] e1 = 32'h0001905A | ((cfg_vmin > 10'd100) ? 32'h1000_0000 : 32'h0);
        logic [31:0] e2 = {2'b10, cfg_vmax, cfg_vmin, (need > 1023) ? 10'd1023 : need[9:0]};
        #1;
        chk(sink_pdo1 == e1, "R6", "sink_pdo1", sink_pdo1, e1);
        chk(sink_pdo2 == e2, "R7", "sink_pdo2", sink_pdo2, e2);
    endtask

    task automatic vbus_check(input int mv);
        @(negedge clk);
        vbus_mv = mv[15:0];
        @(posedge clk);
        @(negedge clk);
        chk(vbus_fault == ref_fault(mv), "R8", "vbus_fault", vbus_fault, ref_fault(mv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 7; i++) ofr_m[i] = '0;
        repeat (3) @(negedge clk);
        chk({busy, done, safe_5v, vbus_fault} == 4'b0, "R10", "reset outputs",
            {busy, done, safe_5v, vbus_fault}, 0);
        chk(sel_pos == 0 && req_volt == 0 && req_curr == 0, "R10", "reset result",
            sel_pos, 0);
        rst = 1'b0;

        // Directed: typical ladder 5/9/15/20 V
        wr_offer(0, mk_pdo(0, 100, 300));
        wr_offer(1, mk_pdo(0, 180, 300));
        wr_offer(2, mk_pdo(0, 300, 300));
        wr_offer(3, mk_pdo(0, 400, 225));
        set_cfg(160, 320, 200, 50);
        caps_check();
        scan_check(4, 1'b0, "R1");
        // R2 inclusive bounds: vmax == 300 and vmin == 300
        set_cfg(300, 300, 100, 0);
        scan_check(4, 1'b0, "R2");
        // R3 equality passes at 20 V, one more fails to 15 V
        set_cfg(100, 400, 200, 25);
        scan_check(4, 1'b0, "R3");
        set_cfg(100, 400, 200, 26);
        scan_check(4, 1'b0, "R3");
        // R4 non-fixed top offer is skipped
        wr_offer(4, mk_pdo(2, 400, 500));
        wr_offer(5, mk_pdo(3, 400, 500));
        set_cfg(100, 400, 10, 0);
        scan_check(6, 1'b0, "R4");
        // R5 fallback, then a match clears safe_5v
        set_cfg(420, 500, 10, 0);
        scan_check(6, 1'b0, "R5");
        scan_check(0, 1'b0, "R5");
        set_cfg(100, 200, 10, 0);
        scan_check(6, 1'b0, "R5");
        // R9 start during a long scan
        set_cfg(450, 460, 10, 0);
        scan_check(6, 1'b1, "R9");
        wr_offer(6, mk_pdo(0, 100, 50));
        set_cfg(100, 100, 40, 10);
        scan_check(7, 1'b1, "R9");
        // R6/R7 edge cases
        set_cfg(100, 100, 1000, 1000);
        caps_check();
        set_cfg(101, 400, 1023, 0);
        caps_check();
        // R8 window boundaries: 4000..24000 mV
        set_cfg(100, 400, 0, 0);
        vbus_check(4000);
        vbus_check(3999);
        vbus_check(24000);
        vbus_check(24001);
        vbus_check(12000);

        // Constrained random
        for (int it = 0; it < 40; it++) begin
            int n = $urandom_range(0, 7);
            int vmin = $urandom_range(60, 300);
            for (int j = 0; j < 7; j++) begin
                int kind = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
                int vsel = $urandom_range(0, 5);
                int v = (vsel == 0) ? 100 : (vsel == 1) ? 180 : (vsel == 2) ? 240 :
                        (vsel == 3) ? 300 : (vsel == 4) ? 400 : $urandom_range(60, 440);
                wr_offer(j, mk_pdo(kind, v, $urandom_range(0, 500)));
            end
            set_cfg(vmin, $urandom_range(vmin, 440), $urandom_range(0, 300),
                    $urandom_range(0, 100));
            caps_check();
            scan_check(n, it[0], "R1");
            vbus_check($urandom_range(0, 30000));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule